// File: doc/BRIEF.md
# Variable-Length Instruction Address Decoder

This block takes an instruction stream one byte per cycle from a byte-addressed memory and splits it into instructions of one, two, three or four bytes. The first byte's upper six bits index a class map that the parameters set. The map marks the instruction as a one-byte form, a two-byte register form or a memory-reference form. For memory-reference forms, a flag in the second byte then chooses between the three-byte form, which carries a 12-bit displacement, and the four-byte form, which carries a 20-bit address.

For memory-reference forms the block computes a 20-bit target address. It adds the field to one of three anchors: the base register, the address of the next instruction, or zero. The index register is added when the index flag is set. All address arithmetic wraps modulo 2^20. A registered result appears with a one-cycle valid pulse. That result holds the opcode, the register numbers, the six addressing flags, the raw field, the target, the length and an illegal-mode flag. Idle cycles may appear between bytes, and a new instruction may start on the cycle after the previous one ends.

Top module: `vlid_decoder`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, out_valid is 0 and every other output is 0.
- R2: A first byte whose class is one-byte completes an instruction by itself. The result has out_len=1 and out_opcode equal to that byte. out_r1, out_r2, out_flags, out_field and out_target are all 0, and out_memref is 0.
- R3: A two-byte form has out_len=2 and out_opcode equal to the first byte. out_r1 is bits 7:4 of the second byte and out_r2 is bits 3:0 of the second byte. out_flags, out_field and out_target are 0.
- R4: A memory form has out_opcode = {byte0[7:2],2'b00} and out_memref=1. out_flags = {n,i,x,b,p,e}, where n=byte0[1], i=byte0[0], x=byte1[7], b=byte1[6], p=byte1[5] and e=byte1[4]. With e=0 the result has out_len=3 and out_field = {byte1[3:0],byte2}, zero-extended. With e=1 the result has out_len=4 and out_field = {byte1[3:0],byte2,byte3}.
- R5: With b=0 and p=0, out_target is out_field, plus the index value when x=1.
- R6: With b=1 and p=0, out_target is base_val + out_field, plus the index value when x=1. The field is taken unsigned.
- R7: With b=0 and p=1, out_target is (start address + out_len) + offset, plus the index value when x=1. In the three-byte form the offset is the 12-bit field sign-extended; in the four-byte form it is the 20-bit field.
- R8: When x=1, index_val is added to the target. Every sum wraps modulo 2^20.
- R9: With b=1 and p=1, out_illegal is 1 and out_target is computed as in R5. In every other case out_illegal is 0.
- R10: out_valid is high for exactly one cycle, on the cycle after the clock edge that samples the final byte, and for no other cycle. Cycles with byte_valid=0 leave the collection state unchanged.
- R11: pc_in is taken as the start address at the clock edge that samples the first byte. base_val and index_val are taken at the edge that samples the final byte.
- R12: Bit k of ONE_MASK marks first bytes with byte0[7:2]=k as one-byte forms. Bit k of TWO_MASK marks them as two-byte forms, and ONE_MASK wins where both are set. Every other value of byte0[7:2] is a memory form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | A stream byte is present this cycle |
| byte_data | input | 8 | Stream byte |
| pc_in | input | 20 | Address of the byte presented, used at the first byte |
| base_val | input | 20 | Base register value |
| index_val | input | 20 | Index register value |
| out_valid | output | 1 | One-cycle result strobe |
| out_len | output | 3 | Instruction length in bytes |
| out_opcode | output | 8 | Opcode, with the low two bits cleared for memory forms |
| out_r1 | output | 4 | First register number |
| out_r2 | output | 4 | Second register number |
| out_flags | output | 6 | {n,i,x,b,p,e} |
| out_field | output | 20 | Displacement or address field |
| out_target | output | 20 | Computed target address |
| out_illegal | output | 1 | b and p both set |
| out_memref | output | 1 | Instruction is a memory form |

## Verification
The bench builds the decoder with ONE_MASK selecting classes 0x30 to 0x33 and TWO_MASK selecting 0x24 to 0x2F. This leaves most of the opcode space as memory forms, so all four lengths appear often in random byte streams. Between bytes, pc_in, base_val and index_val are driven with decoy values, so a decoder that samples them on the wrong byte produces a wrong target. Directed cases reach negative PC-relative offsets, address wrap at the top of the 20-bit space, the illegal flag combination, idle gaps inside an instruction, and back-to-back one-byte instructions.

// File: rtl/vlid_pkg.sv
package vlid_pkg;
  localparam int ADDR_W  = 20;
  localparam int DISP_W  = 12;
  localparam int BYTE_W  = 8;
  localparam int NIB_W   = 4;
  localparam int FLAG_W  = 6;
  localparam int CIDX_W  = 6;
  localparam int LEN_W   = 3;

  typedef enum logic [1:0] {
    CLS_ONE = 2'd0,
    CLS_TWO = 2'd1,
    CLS_MEM = 2'd2
  } op_class_e;

  typedef enum logic [1:0] {
    ST_B0 = 2'd0,
    ST_B1 = 2'd1,
    ST_B2 = 2'd2,
    ST_B3 = 2'd3
  } col_state_e;
endpackage

// File: rtl/vlid_class_lookup.sv
module vlid_class_lookup
  import vlid_pkg::*;
#(
  parameter logic [(1<<CIDX_W)-1:0] ONE_MASK = '0,
  parameter logic [(1<<CIDX_W)-1:0] TWO_MASK = '0
) (
  input  logic [CIDX_W-1:0] idx,
  output op_class_e         cls
);
  localparam int TAB_N = 1 << CIDX_W;

  op_class_e cls_tab [TAB_N];

  // one entry per opcode class index; one-byte marking has priority (R12)
  for (genvar k = 0; k < TAB_N; k++) begin : g_tab
    assign cls_tab[k] = ONE_MASK[k] ? CLS_ONE :
                        TWO_MASK[k] ? CLS_TWO : CLS_MEM;
  end

  assign cls = cls_tab[idx];
endmodule

// File: rtl/vlid_byte_collector.sv
module vlid_byte_collector
  import vlid_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [ADDR_W-1:0] pc_in,
  input  op_class_e         cls_in,
  output op_class_e         cls_eff,
  output logic              done,
  output logic [LEN_W-1:0]  len,
  output logic [BYTE_W-1:0] w0,
  output logic [BYTE_W-1:0] w1,
  output logic [BYTE_W-1:0] w2,
  output logic [BYTE_W-1:0] w3,
  output logic [ADDR_W-1:0] start_pc
);
  col_state_e        st;
  op_class_e         cls_q;
  logic [BYTE_W-1:0] b0_q, b1_q, b2_q;
  logic [ADDR_W-1:0] pc_q;
  logic              last;

  // assemble the instruction with the live byte in its slot
  assign w0       = (st == ST_B0) ? byte_data : b0_q;
  assign w1       = (st == ST_B1) ? byte_data : b1_q;
  assign w2       = (st == ST_B2) ? byte_data : b2_q;
  assign w3       = byte_data;
  assign cls_eff  = (st == ST_B0) ? cls_in : cls_q;
  assign start_pc = (st == ST_B0) ? pc_in  : pc_q;

  always_comb begin
    last = 1'b0;
    len  = 3'd1;
    case (st)
      ST_B0: begin last = (cls_in == CLS_ONE); len = 3'd1; end
      ST_B1: begin last = (cls_q == CLS_TWO);  len = 3'd2; end
      ST_B2: begin last = ~b1_q[4];            len = 3'd3; end
      ST_B3: begin last = 1'b1;                len = 3'd4; end
      default: begin last = 1'b1;              len = 3'd1; end
    endcase
  end

  assign done = byte_valid & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_B0;
      cls_q <= CLS_ONE;
      b0_q  <= '0;
      b1_q  <= '0;
      b2_q  <= '0;
      pc_q  <= '0;
    end else if (byte_valid) begin
      case (st)
        ST_B0: begin
          b0_q  <= byte_data;
          cls_q <= cls_in;
          pc_q  <= pc_in;
          st    <= last ? ST_B0 : ST_B1;
        end
        ST_B1: begin
          b1_q <= byte_data;
          st   <= last ? ST_B0 : ST_B2;
        end
        ST_B2: begin
          b2_q <= byte_data;
          st   <= last ? ST_B0 : ST_B3;
        end
        default: st <= ST_B0;
      endcase
    end
  end

  // R4: the fourth byte is only awaited for a memory form with e set
  a_r4_fourth_needs_e: assert property (@(posedge clk) disable iff (rst)
    (st == ST_B3) |-> (b1_q[4] && cls_q == CLS_MEM));

  // R10: idle cycles leave the collection state untouched
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |=> $stable(st));
endmodule

// File: rtl/vlid_target_calc.sv
module vlid_target_calc
  import vlid_pkg::*;
(
  input  logic              is_long,
  input  logic              fx,
  input  logic              fb,
  input  logic              fp,
  input  logic [ADDR_W-1:0] field,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  output logic [ADDR_W-1:0] target,
  output logic              illegal
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic              pc_rel, base_rel;
  logic [ADDR_W-1:0] anchor, offset, idx_term;

  assign pc_rel   = fp & ~fb;
  assign base_rel = fb & ~fp;

  always_comb begin
    if (pc_rel && !is_long)
      offset = {{EXT_W{field[DISP_W-1]}}, field[DISP_W-1:0]};
    else
      offset = field;
    if (base_rel)
      anchor = base_val;
    else if (pc_rel)
      anchor = next_pc;
    else
      anchor = '0;
  end

  assign idx_term = fx ? index_val : '0;
  assign target   = anchor + offset + idx_term;
  assign illegal  = fb & fp;
endmodule

// File: rtl/vlid_decoder.sv
module vlid_decoder
  import vlid_pkg::*;
#(
  parameter logic [63:0] ONE_MASK = 64'h000F_0000_0000_0000,
  parameter logic [63:0] TWO_MASK = 64'h0000_FFF0_0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic [19:0]       pc_in,
  input  logic [19:0]       base_val,
  input  logic [19:0]       index_val,
  output logic              out_valid,
  output logic [2:0]        out_len,
  output logic [7:0]        out_opcode,
  output logic [3:0]        out_r1,
  output logic [3:0]        out_r2,
  output logic [5:0]        out_flags,
  output logic [19:0]       out_field,
  output logic [19:0]       out_target,
  output logic              out_illegal,
  output logic              out_memref
);
  localparam int PAD_W = ADDR_W - DISP_W;
  localparam int LPAD  = ADDR_W - LEN_W;

  op_class_e         cls_first, cls_eff;
  logic              done;
  logic [LEN_W-1:0]  len;
  logic [BYTE_W-1:0] w0, w1, w2, w3;
  logic [ADDR_W-1:0] start_pc, next_pc, field, calc_target;
  logic              calc_illegal, is_mem, is_two, is_long;
  logic [FLAG_W-1:0] flags;
  logic [BYTE_W-1:0] opcode;
  logic [NIB_W-1:0]  r1, r2;

  vlid_class_lookup #(.ONE_MASK(ONE_MASK), .TWO_MASK(TWO_MASK)) u_lookup (
    .idx (w0[7:2]),
    .cls (cls_first)
  );

  vlid_byte_collector u_collect (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .pc_in      (pc_in),
    .cls_in     (cls_first),
    .cls_eff    (cls_eff),
    .done       (done),
    .len        (len),
    .w0         (w0),
    .w1         (w1),
    .w2         (w2),
    .w3         (w3),
    .start_pc   (start_pc)
  );

  assign is_mem  = (cls_eff == CLS_MEM);
  assign is_two  = (cls_eff == CLS_TWO);
  assign is_long = is_mem & (len == 3'd4);
  assign next_pc = start_pc + {{LPAD{1'b0}}, len};

  always_comb begin
    if (is_long)
      field = {w1[3:0], w2, w3};
    else if (is_mem)
      field = {{PAD_W{1'b0}}, w1[3:0], w2};
    else
      field = '0;
  end

  assign flags  = is_mem ? {w0[1:0], w1[7:4]} : '0;
  assign opcode = is_mem ? {w0[7:2], 2'b00} : w0;
  assign r1     = is_two ? w1[7:4] : '0;
  assign r2     = is_two ? w1[3:0] : '0;

  vlid_target_calc u_target (
    .is_long   (is_long),
    .fx        (w1[7]),
    .fb        (w1[6]),
    .fp        (w1[5]),
    .field     (field),
    .next_pc   (next_pc),
    .base_val  (base_val),
    .index_val (index_val),
    .target    (calc_target),
    .illegal   (calc_illegal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_len     <= '0;
      out_opcode  <= '0;
      out_r1      <= '0;
      out_r2      <= '0;
      out_flags   <= '0;
      out_field   <= '0;
      out_target  <= '0;
      out_illegal <= 1'b0;
      out_memref  <= 1'b0;
    end else begin
      out_valid <= done;
      if (done) begin
        out_len     <= len;
        out_opcode  <= opcode;
        out_r1      <= r1;
        out_r2      <= r2;
        out_flags   <= flags;
        out_field   <= field;
        out_target  <= is_mem ? calc_target : '0;
        out_illegal <= is_mem & calc_illegal;
        out_memref  <= is_mem;
      end
    end
  end

  // R10: a result only follows an edge that took a byte
  a_r10_valid_after_byte: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(byte_valid));

  // R4: a four-byte result always carries e and is a memory form
  a_r4_long_has_e: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len == 3'd4) |-> (out_flags[0] && out_memref));

  // R9: the illegal flag only appears with both b and p set
  a_r9_illegal_flags: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_flags[2] && out_flags[1]));

  // R5: unindexed direct long form targets its own field
  a_r5_direct_long: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len == 3'd4 && out_flags[3:1] == 3'b000) |-> (out_target == out_field));

  // R2: short forms produce no target
  a_r2_short_no_target: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len < 3'd3) |-> (out_target == '0 && !out_memref));
endmodule

// File: tb/vlid_decoder_bench.sv
`timescale 1ns/1ps
module vlid_decoder_bench;
  localparam logic [63:0] TB_ONE = 64'h000F_0000_0000_0000; // classes 0x30..0x33
  localparam logic [63:0] TB_TWO = 64'h0000_FFF0_0000_0000; // classes 0x24..0x2F

  typedef struct packed {
    logic [2:0]  len;
    logic [7:0]  opcode;
    logic [3:0]  r1;
    logic [3:0]  r2;
    logic [5:0]  flags;
    logic [19:0] field;
    logic [19:0] target;
    logic        illegal;
    logic        memref;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [19:0] pc_in = '0, base_val = '0, index_val = '0;
  logic        out_valid, out_illegal, out_memref;
  logic [2:0]  out_len;
  logic [7:0]  out_opcode;
  logic [3:0]  out_r1, out_r2;
  logic [5:0]  out_flags;
  logic [19:0] out_field, out_target;

  int   n_tests = 0;
  int   n_fail  = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  vlid_decoder #(.ONE_MASK(TB_ONE), .TWO_MASK(TB_TWO)) u_vlid_decoder (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .pc_in(pc_in), .base_val(base_val), .index_val(index_val),
    .out_valid(out_valid), .out_len(out_len), .out_opcode(out_opcode),
    .out_r1(out_r1), .out_r2(out_r2), .out_flags(out_flags),
    .out_field(out_field), .out_target(out_target),
    .out_illegal(out_illegal), .out_memref(out_memref)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [2:0] len_of(input logic [7:0] b0, input logic [7:0] b1);
    if (TB_ONE[b0[7:2]]) return 3'd1;
    if (TB_TWO[b0[7:2]]) return 3'd2;
    return b1[4] ? 3'd4 : 3'd3;
  endfunction

  // expected result built from R2..R9, R12
  function automatic exp_t model(input logic [7:0] b0, b1, b2, b3,
                                 input logic [19:0] pc, base, idx);
    exp_t e;
    logic [19:0] anchor, off;
    e = '0;
    e.len = len_of(b0, b1);
    if (e.len == 3'd1) begin
      e.opcode = b0;
    end else if (e.len == 3'd2) begin
      e.opcode = b0; e.r1 = b1[7:4]; e.r2 = b1[3:0];
    end else begin
      e.memref = 1'b1;
      e.opcode = {b0[7:2], 2'b00};
      e.flags  = {b0[1], b0[0], b1[7], b1[6], b1[5], b1[4]};
      e.field  = (e.len == 3'd4) ? {b1[3:0], b2, b3} : {8'h00, b1[3:0], b2};
      off = e.field; anchor = 20'h0;
      if (b1[6] && !b1[5]) anchor = base;
      else if (b1[5] && !b1[6]) begin
        anchor = pc + 20'(e.len);
        if (e.len == 3'd3) off = {{8{b1[3]}}, b1[3:0], b2};
      end
      e.target  = anchor + off + (b1[7] ? idx : 20'h0);
      e.illegal = b1[6] & b1[5];
    end
    return e;
  endfunction

  // driver: pushes the expectation, then presents the bytes with decoys (R11)
  task automatic send(input logic [7:0] b0, b1, b2, b3,
                      input logic [19:0] pc, base, idx, input int gap);
    logic [7:0] bytes [4];
    logic [2:0] n;
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3;
    n = len_of(b0, b1);
    q.push_back(model(b0, b1, b2, b3, pc, base, idx));
    for (int k = 0; k < int'(n); k++) begin
      if (k > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          byte_valid = 1'b0; byte_data = 8'h5A;
        end
      end
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = bytes[k];
      pc_in      = (k == 0) ? pc : ~pc;
      base_val   = (k == int'(n) - 1) ? base : ~base;
      index_val  = (k == int'(n) - 1) ? idx  : ~idx;
    end
  endtask

  task automatic idle(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      byte_valid = 1'b0;
    end
  endtask

  // monitor: compares each valid pulse against the scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        chk("R10 spurious valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        string ttag;
        e = q.pop_front();
        ttag = e.illegal ? "R9 target" : e.flags[2] ? "R6 target" :
               e.flags[1] ? "R7 R11 target" : "R5 target";
        if (e.flags[3]) ttag = {ttag, " R8"};
        chk("R12 R4 len", 32'(out_len), 32'(e.len));
        chk("R2 R4 opcode", 32'(out_opcode), 32'(e.opcode));
        chk("R3 regs", 32'({out_r1, out_r2}), 32'({e.r1, e.r2}));
        chk("R4 flags", 32'(out_flags), 32'(e.flags));
        chk("R4 field", 32'(out_field), 32'(e.field));
        chk(ttag, 32'(out_target), 32'(e.target));
        chk("R9 illegal", 32'(out_illegal), 32'(e.illegal));
        chk("R4 memref", 32'(out_memref), 32'(e.memref));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset valid", 32'(out_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", 32'(out_valid), 32'd0);
    chk("R1 target after reset", 32'(out_target), 32'd0);
    chk("R1 len after reset", 32'(out_len), 32'd0);

    send(8'hC4, 8'h00, 8'h00, 8'h00, 20'h00100, 20'h0, 20'h0, 0);  // R2
    send(8'h90, 8'h35, 8'h00, 8'h00, 20'h00101, 20'h0, 20'h0, 0);  // R3
    send(8'h03, 8'h0A, 8'hBC, 8'h00, 20'h00200, 20'h0, 20'h0, 0);  // R5 direct
    send(8'h07, 8'h41, 8'h23, 8'h00, 20'h00300, 20'h12000, 20'h0, 0); // R6
    send(8'h0B, 8'h2F, 8'hF0, 8'h00, 20'h00010, 20'h0, 20'h0, 0);  // R7 negative
    send(8'h0B, 8'h21, 8'h10, 8'h00, 20'h40000, 20'h0, 20'h0, 0);  // R7 positive
    send(8'h13, 8'h9F, 8'hFF, 8'hFE, 20'h00500, 20'h0, 20'h5, 0);  // R8 wrap, long
    send(8'h17, 8'h53, 8'h45, 8'h67, 20'h00600, 20'hF0000, 20'h0, 0); // R6 long
    send(8'h1B, 8'h60, 8'h77, 8'h00, 20'h00700, 20'h11111, 20'h0, 0); // R9
    send(8'h1B, 8'hE1, 8'h00, 8'h00, 20'h00700, 20'h11111, 20'h22, 0); // R9 indexed
    send(8'h0B, 8'h20, 8'h05, 8'h00, 20'hFFFFE, 20'h0, 20'h0, 0);  // R7 R8 wrap
    send(8'h0B, 8'h31, 8'h00, 8'h10, 20'hFFFF0, 20'h0, 20'h0, 0);  // R7 long
    send(8'h23, 8'hC0, 8'h04, 8'h00, 20'h00800, 20'h01000, 20'h030, 3); // R10 R11 gaps
    send(8'h91, 8'h7E, 8'h00, 8'h00, 20'h00900, 20'h0, 20'h0, 2);  // R3 with gap
    send(8'hCC, 8'h00, 8'h00, 8'h00, 20'h00A00, 20'h0, 20'h0, 0);  // R10 back to back
    send(8'hCD, 8'h00, 8'h00, 8'h00, 20'h00A01, 20'h0, 20'h0, 0);
    send(8'hBF, 8'hAB, 8'h00, 8'h00, 20'h00A02, 20'h0, 20'h0, 0);  // R12 top of two-byte range
    send(8'hC0, 8'h00, 8'h00, 8'h00, 20'h00A04, 20'h0, 20'h0, 0);  // R12 bottom of one-byte range
    send(8'hD3, 8'h00, 8'h12, 8'h00, 20'h00A05, 20'h0, 20'h0, 0);  // R12 0x34 is memory
    idle(3);

    for (int t = 0; t < 200; t++) begin
      send(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
           20'($urandom), 20'($urandom), 20'($urandom), int'($urandom % 3));
    end
    idle(5);
    chk("R10 all results seen", 32'(q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule